// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block turns access requests into memory addresses using a bank of eight register groups. Each group holds an index pointer, a step (modify) value, a ring length and a ring base. A request picks one group's index pointer and, independently, any group's step value, together with a mode. In the mode that adds the step before the access, the address is index plus step and the pointer does not change. In the mode that adds the step after the access, the address is the current pointer and the pointer advances by the step.

When the selected pointer's ring length is nonzero, a pointer that steps past either end of the ring is folded back by one ring length. The fold happens in the same cycle as the access, so it costs nothing. A zero length gives plain linear stepping. A single write port loads any register of any group. Loading a ring base also moves that group's pointer to the base, so the ring starts there.

Top module: `circ_addr_gen`

## Requirements
- R1: Reset (synchronous, active high) clears every pointer, step, length and base register to zero, so an after-step access on any group with step group 0 returns address 0.
- R2: With req_mode = 1 (step-first), addr_out = pointer + step with no ring fold, and the pointer keeps its value.
- R3: With req_mode = 0 (step-after), addr_out = current pointer, and from the next cycle the pointer holds the stepped (and, if needed, folded) value.
- R4: Any pointer group may be paired with any step group in a request.
- R5: When the selected group's length is zero, the new pointer is pointer + step taken modulo 2^32, with no fold, for positive and negative steps.
- R6: When the length L is nonzero and the step is not negative, a stepped pointer at or beyond base + L is reduced by L.
- R7: When the length L is nonzero and the step is negative, a stepped pointer below base is increased by L.
- R8: A write with wr_kind = 3 (base) stores the value in the base register and also in the same group's pointer. wr_kind = 0 writes the pointer, 1 the step, 2 the length.
- R9: When a pointer or base write hits the same group whose pointer an after-step access would update, the written value wins; the access itself still reads the register values from before the write.
- R10: addr_valid equals req_valid. With req_valid low, addr_out is 0 and no pointer changes, whatever the other request fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 pointer, 1 step, 2 length, 3 base |
| wr_grp | input | 3 | Register group written |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Access request strobe |
| req_mode | input | 1 | 0 step-after, 1 step-first |
| req_iptr | input | 3 | Group whose pointer, length and base are used |
| req_mptr | input | 3 | Group whose step value is used |
| addr_valid | output | 1 | Address on addr_out is valid |
| addr_out | output | 32 | Effective address, combinational from the request |

## Verification
The bench drives rings with a length-2 forward step and a length-4 backward step across both ends. A design that folded with the wrong sign, or that compared against base + L - 1, would return an address off by one ring length or a pointer left outside the ring. Step-first accesses are placed between step-after ones, so a design that wrote back in step-first mode, or that folded the step-first address, shows a shifted address. A pointer write and a base write are each issued in the same cycle as a step-after access on that group; a design that let the writeback win would later show the stepped pointer instead of the written one. Idle cycles with live-looking request fields catch a design that updates a pointer without req_valid, and a mid-run reset catches registers that survive reset.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

    parameter int CB_GROUPS = 8;
    parameter int CB_AW     = 32;
    localparam int CB_GW    = $clog2(CB_GROUPS);

    typedef logic [CB_AW-1:0] word_t;
    typedef logic [CB_GW-1:0] gsel_t;

    typedef enum logic [1:0] {
        REG_INDEX  = 2'd0,
        REG_MODIFY = 2'd1,
        REG_LENGTH = 2'd2,
        REG_BASE   = 2'd3
    } reg_kind_e;

    typedef enum logic {
        STEP_POST = 1'b0,
        STEP_PRE  = 1'b1
    } step_mode_e;

    typedef struct packed {
        logic       valid;
        step_mode_e mode;
        gsel_t      iptr;
        gsel_t      mptr;
    } access_t;

    typedef struct packed {
        logic      en;
        reg_kind_e kind;
        gsel_t     grp;
        word_t     data;
    } regwr_t;

    typedef struct packed {
        word_t idx;
        word_t mod;
        word_t len;
        word_t base;
    } grp_view_t;

    function automatic word_t cb_mag(input word_t v);
        return v[CB_AW-1] ? (~v + word_t'(1)) : v;
    endfunction

    function automatic logic cb_in_ring(input word_t v, input word_t base,
                                        input word_t len);
        return (v - base) < len;
    endfunction

endpackage

// File: rtl/cbag_regfile.sv
module cbag_regfile
    import cbag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  regwr_t    wr,
    input  gsel_t     iptr,
    input  gsel_t     mptr,
    input  logic      wb_en,
    input  gsel_t     wb_grp,
    input  word_t     wb_val,
    output grp_view_t view
);

    logic [CB_GROUPS-1:0][CB_AW-1:0] idx_q;
    logic [CB_GROUPS-1:0][CB_AW-1:0] mod_q;
    logic [CB_GROUPS-1:0][CB_AW-1:0] len_q;
    logic [CB_GROUPS-1:0][CB_AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else begin
            for (int g = 0; g < CB_GROUPS; g++) begin
                // external pointer or base write outranks the access writeback
                if (wr.en && wr.grp == gsel_t'(g) &&
                    (wr.kind == REG_INDEX || wr.kind == REG_BASE))
                    idx_q[g] <= wr.data;
                else if (wb_en && wb_grp == gsel_t'(g))
                    idx_q[g] <= wb_val;
                if (wr.en && wr.grp == gsel_t'(g) && wr.kind == REG_MODIFY)
                    mod_q[g] <= wr.data;
                if (wr.en && wr.grp == gsel_t'(g) && wr.kind == REG_LENGTH)
                    len_q[g] <= wr.data;
                if (wr.en && wr.grp == gsel_t'(g) && wr.kind == REG_BASE)
                    base_q[g] <= wr.data;
            end
        end
    end

    always_comb begin
        view.idx  = idx_q[iptr];
        view.len  = len_q[iptr];
        view.base = base_q[iptr];
        view.mod  = mod_q[mptr];
    end

    AST_POST_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !(wr.en && wr.grp == wb_grp &&
                    (wr.kind == REG_INDEX || wr.kind == REG_BASE)))
        |=> idx_q[$past(wb_grp)] == $past(wb_val)); // R3

    AST_BASE_LOADS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.kind == REG_BASE)
        |=> (idx_q[$past(wr.grp)] == $past(wr.data) &&
             base_q[$past(wr.grp)] == $past(wr.data))); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.kind == REG_INDEX && wb_en && wb_grp == wr.grp)
        |=> idx_q[$past(wr.grp)] == $past(wr.data)); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wb_en && !wr.en) |=> $stable(idx_q)); // R10

endmodule

// File: rtl/cbag_ring_fold.sv
module cbag_ring_fold
    import cbag_pkg::*;
#(
    parameter bit FOLD_BY_SIGN = 1'b1
) (
    input  word_t sum,
    input  logic  mod_neg,
    input  word_t len,
    input  word_t base,
    output word_t folded
);

    generate
        if (FOLD_BY_SIGN) begin : g_sign
            // one offset compare; the step sign picks the fold direction
            word_t off;
            assign off = sum - base;
            always_comb begin
                if (len == '0)
                    folded = sum;
                else if (off >= len)
                    folded = mod_neg ? (sum + len) : (sum - len);
                else
                    folded = sum;
            end
        end else begin : g_bounds
            // two explicit bound compares, each gated by step direction
            word_t top_b;
            assign top_b = base + len;
            always_comb begin
                if (len == '0)
                    folded = sum;
                else if (mod_neg && sum < base)
                    folded = sum + len;
                else if (!mod_neg && sum >= top_b)
                    folded = sum - len;
                else
                    folded = sum;
            end
        end
    endgenerate

endmodule

// File: rtl/cbag_step_unit.sv
module cbag_step_unit
    import cbag_pkg::*;
#(
    parameter bit FOLD_BY_SIGN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  step_mode_e mode,
    input  grp_view_t  view,
    output word_t      eff_addr,
    output logic       wb_en,
    output word_t      next_idx
);

    word_t sum;

    assign sum = view.idx + view.mod;

    cbag_ring_fold #(.FOLD_BY_SIGN(FOLD_BY_SIGN)) u_fold (
        .sum     (sum),
        .mod_neg (view.mod[CB_AW-1]),
        .len     (view.len),
        .base    (view.base),
        .folded  (next_idx)
    );

    always_comb begin
        eff_addr = (mode == STEP_PRE) ? sum : view.idx;
        wb_en    = valid && (mode == STEP_POST);
    end

    AST_LINEAR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == STEP_POST && view.len == '0)
        |-> next_idx == view.idx + view.mod); // R5

    AST_RING_FWD_CONTAINED: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == STEP_POST && view.len != '0 && !view.mod[CB_AW-1] &&
         cb_in_ring(view.idx, view.base, view.len) && view.mod <= view.len)
        |-> cb_in_ring(next_idx, view.base, view.len)); // R6

    AST_RING_BACK_CONTAINED: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == STEP_POST && view.len != '0 && view.mod[CB_AW-1] &&
         cb_in_ring(view.idx, view.base, view.len) &&
         cb_mag(view.mod) <= view.len)
        |-> cb_in_ring(next_idx, view.base, view.len)); // R7

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import cbag_pkg::*;
#(
    parameter bit FOLD_BY_SIGN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [CB_GW-1:0] wr_grp,
    input  logic [CB_AW-1:0] wr_data,
    input  logic             req_valid,
    input  logic             req_mode,
    input  logic [CB_GW-1:0] req_iptr,
    input  logic [CB_GW-1:0] req_mptr,
    output logic             addr_valid,
    output logic [CB_AW-1:0] addr_out
);

    access_t   acc;
    regwr_t    wr;
    grp_view_t view;
    word_t     eff_addr;
    word_t     next_idx;
    logic      wb_en;

    always_comb begin
        acc.valid = req_valid;
        acc.mode  = step_mode_e'(req_mode);
        acc.iptr  = req_iptr;
        acc.mptr  = req_mptr;
        wr.en     = wr_en;
        wr.kind   = reg_kind_e'(wr_kind);
        wr.grp    = wr_grp;
        wr.data   = wr_data;
    end

    cbag_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .iptr   (acc.iptr),
        .mptr   (acc.mptr),
        .wb_en  (wb_en),
        .wb_grp (acc.iptr),
        .wb_val (next_idx),
        .view   (view)
    );

    cbag_step_unit #(.FOLD_BY_SIGN(FOLD_BY_SIGN)) u_step (
        .clk      (clk),
        .rst      (rst),
        .valid    (acc.valid),
        .mode     (acc.mode),
        .view     (view),
        .eff_addr (eff_addr),
        .wb_en    (wb_en),
        .next_idx (next_idx)
    );

    assign addr_valid = acc.valid;
    assign addr_out   = acc.valid ? eff_addr : '0;

endmodule

// File: tb/sim_circ_addr_gen.sv
module sim_circ_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_grp = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [2:0]  req_iptr = '0;
    logic [2:0]  req_mptr = '0;
    logic        addr_valid;
    logic [31:0] addr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    circ_addr_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_grp(wr_grp), .wr_data(wr_data), .req_valid(req_valid),
        .req_mode(req_mode), .req_iptr(req_iptr), .req_mptr(req_mptr),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  kind;
        logic [2:0]  grp;
        logic [31:0] data;
        logic        rq;
        logic        pre;
        logic [2:0]  ip;
        logic [2:0]  mp;
        logic [31:0] exp;
        logic [7:0]  rid;
    } vec_t;

    function automatic vec_t wv(input logic [1:0] k, input logic [2:0] g,
                                input logic [31:0] d);
        return '{1'b1, k, g, d, 1'b0, 1'b0, 3'd0, 3'd0, 32'd0, 8'd0};
    endfunction

    function automatic vec_t av(input logic p, input logic [2:0] i,
                                input logic [2:0] m, input logic [31:0] e,
                                input logic [7:0] r);
        return '{1'b0, 2'd0, 3'd0, 32'd0, 1'b1, p, i, m, e, r};
    endfunction

    // kinds: 0 pointer, 1 step, 2 length, 3 base; mode 0 after, 1 first
    localparam int NV = 24;
    localparam vec_t TABLE [0:NV-1] = '{
        wv(2'd3, 3'd1, 32'd100),              // R8 ring base 100
        wv(2'd1, 3'd2, 32'd1),
        wv(2'd2, 3'd1, 32'd2),                // ring length 2
        av(1'b0, 3'd1, 3'd2, 32'd100, 8'd3),  // R3
        av(1'b0, 3'd1, 3'd2, 32'd101, 8'd6),  // R6 102 folds to 100
        av(1'b0, 3'd1, 3'd2, 32'd100, 8'd6),  // R6
        av(1'b1, 3'd1, 3'd2, 32'd102, 8'd2),  // R2 no fold on address
        av(1'b0, 3'd1, 3'd2, 32'd101, 8'd2),  // R2 pointer kept
        wv(2'd0, 3'd3, 32'd1000),
        wv(2'd1, 3'd4, 32'hFFFF_FFFC),
        av(1'b0, 3'd3, 3'd4, 32'd1000, 8'd5), // R5
        av(1'b0, 3'd3, 3'd4, 32'd996, 8'd5),  // R5
        av(1'b1, 3'd3, 3'd2, 32'd993, 8'd4),  // R4
        wv(2'd3, 3'd5, 32'd200),
        wv(2'd2, 3'd5, 32'd4),
        wv(2'd1, 3'd6, 32'hFFFF_FFFD),
        av(1'b0, 3'd5, 3'd6, 32'd200, 8'd7),  // R7 197 folds to 201
        av(1'b0, 3'd5, 3'd6, 32'd201, 8'd7),  // R7 198 folds to 202
        av(1'b0, 3'd5, 3'd2, 32'd202, 8'd6),  // R6
        av(1'b0, 3'd5, 3'd2, 32'd203, 8'd6),  // R6 204 folds to 200
        av(1'b0, 3'd5, 3'd6, 32'd200, 8'd7),  // R7
        wv(2'd1, 3'd7, 32'd5),
        av(1'b1, 3'd0, 3'd7, 32'd5, 8'd4),    // R4
        av(1'b0, 3'd5, 3'd0, 32'd201, 8'd3)   // R3
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns before the rising edge
    task automatic cyc(input vec_t v, input bit chk, input string tag);
        @(negedge clk);
        wr_en     = v.wr;
        wr_kind   = v.kind;
        wr_grp    = v.grp;
        wr_data   = v.data;
        req_valid = v.rq;
        req_mode  = v.pre;
        req_iptr  = v.ip;
        req_mptr  = v.mp;
        #3;
        if (chk) begin
            check({tag, " valid"}, {31'd0, addr_valid}, 32'd1);
            check(tag, addr_out, v.exp);
        end
    endtask

    task automatic idle_cyc(input logic [2:0] ip, input logic [2:0] mp);
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0; req_mode = 1'b0;
        req_iptr = ip; req_mptr = mp;
        #3;
        check("R10 idle valid", {31'd0, addr_valid}, 32'd0);
        check("R10 idle addr", addr_out, 32'd0);
    endtask

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        check("R1 reset valid", {31'd0, addr_valid}, 32'd0);
        for (int g = 0; g < 8; g++)
            cyc(av(1'b0, 3'(g), 3'd0, 32'd0, 8'd1), 1'b1, "R1 cleared pointer");

        for (int k = 0; k < NV; k++) begin
            v = TABLE[k];
            cyc(v, v.rq, $sformatf("R%0d table step %0d", v.rid, k));
        end

        // R8: base write moves the pointer
        cyc(wv(2'd3, 3'd2, 32'd300), 1'b0, "");
        cyc(av(1'b0, 3'd2, 3'd0, 32'd300, 8'd8), 1'b1, "R8 base loads pointer");

        // R9: pointer write in the same cycle as a step-after access
        v = av(1'b0, 3'd3, 3'd7, 32'd992, 8'd9);
        v.wr = 1'b1; v.kind = 2'd0; v.grp = 3'd3; v.data = 32'd700;
        cyc(v, 1'b1, "R9 access reads old pointer");
        cyc(av(1'b0, 3'd3, 3'd0, 32'd700, 8'd9), 1'b1, "R9 pointer write wins");

        // R9: base write in the same cycle as a step-after access
        v = av(1'b0, 3'd3, 3'd2, 32'd700, 8'd9);
        v.wr = 1'b1; v.kind = 2'd3; v.grp = 3'd3; v.data = 32'd800;
        cyc(v, 1'b1, "R9 access before base write");
        cyc(av(1'b0, 3'd3, 3'd0, 32'd800, 8'd9), 1'b1, "R9 base write wins");

        // R10: idle cycles with request fields aimed at group 2
        for (int k = 0; k < 3; k++) idle_cyc(3'd2, 3'd2);
        cyc(av(1'b0, 3'd2, 3'd0, 32'd300, 8'd10), 1'b1, "R10 pointer untouched");

        // R1: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cyc(av(1'b0, 3'd1, 3'd0, 32'd0, 8'd1), 1'b1, "R1 pointer after reset");
        cyc(av(1'b1, 3'd5, 3'd6, 32'd0, 8'd1), 1'b1, "R1 step after reset");

        @(negedge clk);
        req_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule